// File: doc/BRIEF.md
# Counter Overflow Status and Interrupt-Pending Collector

This block gathers the sticky overflow flags of the programmable event counters (channels 3 to 31) into one 32-bit read-only status word for supervisor software. Bit X of the word belongs to counter X. Each bit is shown only when the reader's privilege mode and virtualization state are allowed to see that counter. The allowance comes from a machine-level counter-enable mask and, for a virtualized supervisor, also from a hypervisor-level mask.

The block also holds the local count-overflow interrupt-pending bit and its enable bit. Both sit at bit 13 of their registers. The pending bit is set whenever any counter channel raises an overflow request, and software clears it after servicing. The block drives `irq_active` (pending AND enable) to the interrupt arbitration downstream. The block does no arbitration itself.

Software reaches the three registers through a plain CSR port. The read data is combinational on the address. A write takes effect at the next rising clock edge. The port has no stall and no back-pressure.

Top module: `ovf_status_agg`

## Requirements
- R1: At the status address (0xD33), read bit X for X in 3..31 equals `of_flags[X]` whenever counter X is visible to the reader.
- R2: Status read bits 0, 1 and 2 are always zero, whatever `of_flags` holds.
- R3: With `priv_mode` = 2'b11 (machine), or with `priv_mode` = 2'b01 (supervisor) and `virt_mode` = 0, status bit X is visible only when `mcen[X]` = 1. Otherwise it reads as zero.
- R4: With `priv_mode` = 2'b01 and `virt_mode` = 1 (virtualized supervisor), status bit X is visible only when both `mcen[X]` and `hcen[X]` are 1.
- R5: With `priv_mode` = 2'b00 (user) or the reserved code 2'b10, the status word reads as all zeros.
- R6: A 1 on any `ovf_req` bit in 3..31 at a rising edge sets the pending bit. Request bits 0..2 have no effect.
- R7: A write to the pending address (0x344) loads `csr_wdata[13]` into the pending bit. If a hardware request arrives in the same cycle, the pending bit ends up set.
- R8: A write to the enable address (0x304) loads `csr_wdata[13]` into the enable bit. Reads of either address return the bit at position 13 and zero in every other position. `irq_active` equals pending AND enable.
- R9: With parameter IMPL = 0, the pending and enable bits read as zero, writes to them are ignored, and `irq_active` stays 0.
- R10: After reset, the pending bit, the enable bit and `irq_active` are all 0.
- R11: Writes to the status address change nothing, and reads of any unmapped address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| of_flags | input | 32 | Sticky overflow flag of each counter channel |
| ovf_req | input | 32 | One-cycle overflow interrupt request of each channel |
| mcen | input | 32 | Machine-level counter-enable mask |
| hcen | input | 32 | Hypervisor-level counter-enable mask |
| priv_mode | input | 2 | Reader privilege: 00 user, 01 supervisor, 11 machine |
| virt_mode | input | 1 | Reader runs virtualized |
| csr_addr | input | 12 | CSR address for read and write |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data, combinational on the address |
| irq_active | output | 1 | Pending AND enable, to interrupt arbitration |

## Verification
The bench builds two copies of the block side by side, with the same stimulus. One uses the default parameters (32-bit word, first channel 3, IMPL = 1). With it, every mode, mask and pending interaction can be reached, including a set and a clear in the same cycle. The other uses IMPL = 0, which brings the hardwired-zero variant of the bit-13 pair within reach. The random enable masks and flag words exercise each visible bit in all four privilege encodings.

// File: rtl/ovfagg_pkg.sv
package ovfagg_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  localparam int unsigned CSR_AW = 12;
endpackage

// File: rtl/ovf_view_mask.sv
module ovf_view_mask
  import ovfagg_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned FIRST_CH = 3
) (
  input  logic [W-1:0] of_flags,
  input  logic [W-1:0] mcen,
  input  logic [W-1:0] hcen,
  input  logic [1:0]   priv_mode,
  input  logic         virt_mode,
  output logic [W-1:0] view
);
  localparam logic [W-1:0] CH_MASK = {W{1'b1}} << FIRST_CH;

  logic [W-1:0] grant;

  always_comb begin
    unique case (priv_e'(priv_mode))
      PRIV_M:  grant = mcen;
      PRIV_S:  grant = virt_mode ? (mcen & hcen) : mcen;
      default: grant = '0;
    endcase
  end

  assign view = of_flags & grant & CH_MASK;
endmodule

// File: rtl/lcofi_pending.sv
module lcofi_pending #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_pend_we,
  input  logic sw_pend_val,
  input  logic sw_en_we,
  input  logic sw_en_val,
  output logic pend,
  output logic en
);
  generate
    if (IMPL) begin : g_impl
      logic pend_r, en_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_r <= 1'b0;
          en_r   <= 1'b0;
        end else begin
          if (hw_set)          pend_r <= 1'b1;
          else if (sw_pend_we) pend_r <= sw_pend_val;
          if (sw_en_we)        en_r   <= sw_en_val;
        end
      end
      assign pend = pend_r;
      assign en   = en_r;
    end else begin : g_tied
      logic unused_in;
      assign unused_in = ^{clk, rst_n, hw_set, sw_pend_we, sw_pend_val, sw_en_we, sw_en_val};
      assign pend = 1'b0;
      assign en   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ovf_status_agg.sv
module ovf_status_agg
  import ovfagg_pkg::*;
#(
  parameter int unsigned W           = 32,
  parameter int unsigned FIRST_CH    = 3,
  parameter bit          IMPL        = 1'b1,
  parameter int unsigned IRQ_BIT     = 13,
  parameter logic [11:0] STATUS_ADDR = 12'hD33,
  parameter logic [11:0] PEND_ADDR   = 12'h344,
  parameter logic [11:0] ENAB_ADDR   = 12'h304
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] of_flags,
  input  logic [W-1:0] ovf_req,
  input  logic [W-1:0] mcen,
  input  logic [W-1:0] hcen,
  input  logic [1:0]   priv_mode,
  input  logic         virt_mode,
  input  logic [11:0]  csr_addr,
  input  logic         csr_we,
  input  logic [W-1:0] csr_wdata,
  output logic [W-1:0] csr_rdata,
  output logic         irq_active
);
  localparam logic [W-1:0] CH_MASK = {W{1'b1}} << FIRST_CH;

  logic [W-1:0] status_view;
  logic         any_req;
  logic         pend_q, en_q;
  logic         unused_wdata;

  assign unused_wdata = ^csr_wdata;
  assign any_req      = |(ovf_req & CH_MASK);

  ovf_view_mask #(.W(W), .FIRST_CH(FIRST_CH)) u_view (
    .of_flags  (of_flags),
    .mcen      (mcen),
    .hcen      (hcen),
    .priv_mode (priv_mode),
    .virt_mode (virt_mode),
    .view      (status_view)
  );

  lcofi_pending #(.IMPL(IMPL)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_set      (any_req),
    .sw_pend_we  (csr_we && csr_addr == PEND_ADDR),
    .sw_pend_val (csr_wdata[IRQ_BIT]),
    .sw_en_we    (csr_we && csr_addr == ENAB_ADDR),
    .sw_en_val   (csr_wdata[IRQ_BIT]),
    .pend        (pend_q),
    .en          (en_q)
  );

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == STATUS_ADDR)    csr_rdata = status_view;
    else if (csr_addr == PEND_ADDR) csr_rdata[IRQ_BIT] = pend_q;
    else if (csr_addr == ENAB_ADDR) csr_rdata[IRQ_BIT] = en_q;
  end

  assign irq_active = pend_q & en_q;
endmodule

// File: rtl/ovf_status_agg_chk.sv
module ovf_status_agg_chk #(
  parameter int unsigned W           = 32,
  parameter int unsigned FIRST_CH    = 3,
  parameter bit          IMPL        = 1'b1,
  parameter int unsigned IRQ_BIT     = 13,
  parameter logic [11:0] STATUS_ADDR = 12'hD33,
  parameter logic [11:0] PEND_ADDR   = 12'h344
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] ovf_req,
  input logic [W-1:0] mcen,
  input logic [W-1:0] hcen,
  input logic [1:0]   priv_mode,
  input logic         virt_mode,
  input logic [11:0]  csr_addr,
  input logic         csr_we,
  input logic [W-1:0] csr_wdata,
  input logic [W-1:0] csr_rdata,
  input logic         irq_active,
  input logic         pend_q
);
  localparam logic [W-1:0] CH_MASK = {W{1'b1}} << FIRST_CH;
  logic st_rd;
  assign st_rd = (csr_addr == STATUS_ADDR);

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |-> (csr_rdata & ~CH_MASK) == '0); // R2
  AST_PLAIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && (priv_mode == 2'b11 || (priv_mode == 2'b01 && !virt_mode)))
      |-> (csr_rdata & ~mcen) == '0); // R3
  AST_VIRT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && priv_mode == 2'b01 && virt_mode)
      |-> (csr_rdata & ~(mcen & hcen)) == '0); // R4
  AST_USER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && (priv_mode == 2'b00 || priv_mode == 2'b10)) |-> csr_rdata == '0); // R5
  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (IMPL && (ovf_req & CH_MASK) != '0) |=> pend_q); // R6
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_req & CH_MASK) == '0 && !(csr_we && csr_addr == PEND_ADDR)) |=> $stable(pend_q)); // R7
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_req & CH_MASK) == '0 && csr_we && csr_addr == PEND_ADDR && !csr_wdata[IRQ_BIT])
      |=> !pend_q); // R7
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_active |-> pend_q); // R8
  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!IMPL) |-> !irq_active); // R9
endmodule

bind ovf_status_agg ovf_status_agg_chk #(
  .W(W), .FIRST_CH(FIRST_CH), .IMPL(IMPL), .IRQ_BIT(IRQ_BIT),
  .STATUS_ADDR(STATUS_ADDR), .PEND_ADDR(PEND_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ovf_req(ovf_req), .mcen(mcen), .hcen(hcen),
  .priv_mode(priv_mode), .virt_mode(virt_mode), .csr_addr(csr_addr),
  .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
  .irq_active(irq_active), .pend_q(pend_q)
);

// File: tb/ovf_status_agg_bench.sv
module ovf_status_agg_bench;
  localparam logic [11:0] A_ST = 12'hD33, A_PD = 12'h344, A_EN = 12'h304;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] of_flags = '0, ovf_req = '0, mcen = '0, hcen = '0, csr_wdata = '0;
  logic [1:0]  priv_mode = 2'b11;
  logic        virt_mode = 1'b0, csr_we = 1'b0;
  logic [11:0] csr_addr = 12'h000;
  logic [31:0] rd_a, rd_b;
  logic        irq_a, irq_b;

  int checks = 0, errors = 0;
  bit m_pend = 1'b0, m_en = 1'b0;

  always #4 clk = ~clk;

  ovf_status_agg u_ovf_status_agg (
    .clk(clk), .rst_n(rst_n), .of_flags(of_flags), .ovf_req(ovf_req), .mcen(mcen),
    .hcen(hcen), .priv_mode(priv_mode), .virt_mode(virt_mode), .csr_addr(csr_addr),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(rd_a), .irq_active(irq_a));

  ovf_status_agg #(.IMPL(1'b0)) u_absent (
    .clk(clk), .rst_n(rst_n), .of_flags(of_flags), .ovf_req(ovf_req), .mcen(mcen),
    .hcen(hcen), .priv_mode(priv_mode), .virt_mode(virt_mode), .csr_addr(csr_addr),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(rd_b), .irq_active(irq_b));

  function automatic logic [31:0] vis_mask(logic [1:0] pm, logic vt, logic [31:0] mc, logic [31:0] hc);
    if (pm == 2'b11) return mc;
    if (pm == 2'b01) return vt ? (mc & hc) : mc;
    return '0;
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a, bit impl, bit p, bit e);
    if (a == A_ST) return of_flags & vis_mask(priv_mode, virt_mode, mcen, hcen) & 32'hFFFF_FFF8;
    if (a == A_PD) return impl ? (32'(p) << 13) : 32'h0;
    if (a == A_EN) return impl ? (32'(e) << 13) : 32'h0;
    return '0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [11:0] a);
    if (a == A_ST) return (priv_mode == 2'b01 && virt_mode) ? "R4 R1 R2" :
                          (priv_mode[0] ? "R3 R1 R2" : "R5");
    if (a == A_PD) return "R6 R7";
    if (a == A_EN) return "R8";
    return "R11";
  endfunction

  task automatic step(logic [31:0] of, logic [31:0] rq, logic [31:0] mc, logic [31:0] hc,
                      logic [1:0] pm, logic vt, logic [11:0] a, logic we, logic [31:0] wd);
    @(negedge clk);
    of_flags = of; ovf_req = rq; mcen = mc; hcen = hc; priv_mode = pm; virt_mode = vt;
    csr_addr = a; csr_we = we; csr_wdata = wd;
    #1;
    chk(tag_of(a), rd_a, exp_read(a, 1'b1, m_pend, m_en));
    chk("R9 read", rd_b, exp_read(a, 1'b0, 1'b0, 1'b0));
    chk("R8 irq_active", 32'(irq_a), 32'(m_pend & m_en));
    chk("R9 irq_active", 32'(irq_b), 32'h0);
    if ((rq & 32'hFFFF_FFF8) != 0) m_pend = 1'b1;
    else if (we && a == A_PD) m_pend = wd[13];
    if (we && a == A_EN) m_en = wd[13];
    @(posedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10: reset values
    csr_addr = A_PD; #1; chk("R10 pend", rd_a, 32'h0);
    csr_addr = A_EN; #1; chk("R10 en", rd_a, 32'h0);
    chk("R10 irq", 32'(irq_a), 32'h0);
    // R2: low bits hidden even with everything enabled
    step('1, '0, '1, '1, 2'b11, 1'b0, A_ST, 1'b0, '0);
    // R6: low request bits ignored
    step('0, 32'h7, '0, '0, 2'b11, 1'b0, A_PD, 1'b0, '0);
    step('0, '0, '0, '0, 2'b11, 1'b0, A_PD, 1'b0, '0);
    // R6/R8: high request sets pending, enable then raises irq
    step('0, 32'h8000_0000, '0, '0, 2'b11, 1'b0, A_EN, 1'b1, 32'h2000);
    step('0, '0, '0, '0, 2'b11, 1'b0, A_PD, 1'b0, '0);
    // R7: clear by software, then set wins over same-cycle clear
    step('0, '0, '0, '0, 2'b11, 1'b0, A_PD, 1'b1, 32'h0);
    step('0, 32'h10, '0, '0, 2'b11, 1'b0, A_PD, 1'b1, 32'h0);
    step('0, '0, '0, '0, 2'b11, 1'b0, A_PD, 1'b0, '0);
    // R11: status write ignored, unmapped reads zero
    step(32'hF0F0_F0F8, '0, '1, '0, 2'b01, 1'b0, A_ST, 1'b1, 32'hFFFF_FFFF);
    step(32'hF0F0_F0F8, '0, '1, '0, 2'b01, 1'b0, A_ST, 1'b0, '0);
    step('1, '0, '1, '1, 2'b11, 1'b0, 12'h123, 1'b1, '1);
    // R4 / R5 directed
    step('1, '0, 32'hFFFF_0000, 32'h00FF_FF00, 2'b01, 1'b1, A_ST, 1'b0, '0);
    step('1, '0, '1, '1, 2'b00, 1'b0, A_ST, 1'b0, '0);
    step('1, '0, '1, '1, 2'b10, 1'b1, A_ST, 1'b0, '0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [31:0] rq;
      case ($urandom % 4)
        0: a = A_ST; 1: a = A_PD; 2: a = A_EN; default: a = 12'($urandom);
      endcase
      if (($urandom % 4) < 2) a = A_ST;
      rq = (($urandom % 6) == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      step($urandom, rq, $urandom, $urandom, 2'($urandom), 1'($urandom), a,
           (($urandom % 4) == 0), $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule